// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block picks the input, or the input pair, that a multiplexed eight-input converter samples on each conversion. A 14-bit configuration word arrives one bit at a time, most significant bit first, while a conversion is running. A frame-end strobe closes the frame. On every conversion-start strobe the block registers the positive channel index, the negative side and a temperature-sensor select. The negative side is either the odd partner of an even channel or the common (ground-sense) input.

The block has three states. `ST_FIXED` converts the single channel held in the word. `ST_SCAN` steps a cursor from input 0 up to a programmed last channel, either one input at a time or one even/odd pair at a time. `ST_TEMP` is one extra slot for a temperature reading at the end of each pass. On a conversion start, `ST_SCAN` either advances (step) or leaves the last channel. When it leaves, it goes to `ST_TEMP` (temp insert) or back to input 0 (wrap). `ST_TEMP` always returns to `ST_SCAN` at input 0 (temp return). A staged word is applied on a conversion start. Applying it can force `ST_FIXED` (disable), force `ST_SCAN` at input 0 (start or restart), or leave the scan running (update in place).

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the outputs select positive channel 7 against the common input, temperature select low, `sel_valid` low. No scan runs until a word that starts one is committed.
- R2: A frame is committed only if at least 14 bits were shifted before `frame_end` and bit 13 (the first of the last 14 bits shifted) is 1. When bit 13 is 0 the previous configuration stays in force. Word fields: bit 11 set = single-ended, clear = paired. Bits 9:7 = channel / last channel. Bits 2:1 = scan code. Other bits do not affect the selection.
- R3: A frame with fewer than 14 bits before `frame_end` is discarded.
- R4: A word committed during the frame of conversion k is first used for conversion k+2. Conversion k+1 still uses the previous configuration.
- R5: With scan code 00 every conversion uses channel bits 9:7 as the positive side. The negative side is the common input when single-ended, and channel XOR 1 when paired.
- R6: With a scan running in single-ended mode, conversions visit inputs 0,1,...,last against the common input, then wrap to 0.
- R7: With a scan running in paired mode, conversions visit even inputs 0,2,... with the next odd input as the negative side. The last pair is the one containing channel bits 9:7. The positive index is always even.
- R8: Scan code 10 inserts one temperature conversion after the last channel of each pass. In that slot `temp_sel`=1, `pos_ch`=0, `neg_ch`=0 and `neg_com`=0. Scan code 11 inserts none. Either code restarts the scan at input 0.
- R9: Scan code 01 that leaves bits 11 and 9:7 unchanged updates the word without disturbing the running scan position or the temperature setting.
- R10: Scan code 01 that changes bit 11 or bits 9:7 during a scan restarts at input 0 (pair 0/1 in paired mode).
- R11: Outputs change only on the edge that samples `conv_start`. `sel_valid` is high for the one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bit | input | 1 | Serial configuration data, MSB first |
| cfg_bit_en | input | 1 | Shifts `cfg_bit` in on this cycle |
| frame_end | input | 1 | Closes the current configuration frame |
| conv_start | input | 1 | Starts a conversion; registers the next selection |
| pos_ch | output | 3 | Positive input index |
| neg_ch | output | 3 | Negative input index when not common |
| neg_com | output | 1 | Negative side is the common input |
| temp_sel | output | 1 | Temperature sensor selected |
| sel_valid | output | 1 | Pulse: selection just updated |

## Verification
Directed runs come first. They cover a fixed single channel, a fixed pair with an odd channel, a paired scan whose last channel is odd, and a single-ended scan with temperature insertion. These separate the step size, the pair rounding and the temperature slot. Bad frames are tried next: short frames and frames with a low leading bit. They show whether a discarded word leaks into the selection. The 01 updates, with and without a change to the mode or last-channel field, show the difference between restarting and continuing. A long seeded random mix of frames and conversions is then compared, one conversion at a time, against a bench model, which exposes any error in the two-conversion latency.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
    localparam int CFG_W    = 14;
    localparam int CH_W     = 3;
    localparam int B_LEAD   = 13;
    localparam int B_SINGLE = 11;
    localparam int CH_HI    = 9;
    localparam int CH_LO    = 7;
    localparam int SQ_HI    = 2;
    localparam int SQ_LO    = 1;

    typedef enum logic [1:0] {
        ST_FIXED = 2'd0,
        ST_SCAN  = 2'd1,
        ST_TEMP  = 2'd2
    } scan_st_e;

    typedef struct packed {
        logic [CH_W-1:0] pos;
        logic [CH_W-1:0] neg;
        logic            neg_com;
        logic            temp;
    } sel_t;
endpackage

// File: rtl/adcseq_cfg_shift.sv
module adcseq_cfg_shift
    import adcseq_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_in,
    input  logic         bit_en,
    input  logic         frame_end,
    input  logic         conv_start,
    output logic [W-1:0] stg_word,
    output logic         stg_pend
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] FULL = CW'(W);

    logic [W-1:0]  sh_q;
    logic [CW-1:0] cnt_q;
    logic          accept;

    assign accept = frame_end && (cnt_q == FULL) && sh_q[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q     <= '0;
            cnt_q    <= '0;
            stg_word <= '1;
            stg_pend <= 1'b0;
        end else begin
            if (bit_en) begin
                sh_q <= {sh_q[W-2:0], bit_in};
            end
            if (frame_end) begin
                cnt_q <= '0;
            end else if (bit_en && cnt_q != FULL) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (accept) begin
                stg_word <= sh_q;
                stg_pend <= 1'b1;
            end else if (conv_start) begin
                stg_pend <= 1'b0;
            end
        end
    end

    assert_short_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && cnt_q != FULL) |=> $stable(stg_word));

    assert_lead_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !sh_q[W-1]) |=> $stable(stg_word));
endmodule

// File: rtl/adcseq_chan_map.sv
module adcseq_chan_map
    import adcseq_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  scan_st_e        st,
    input  logic [CH_W-1:0] cur,
    input  logic [W-1:0]    act,
    output sel_t            sel
);
    logic            single;
    logic [CH_W-1:0] fix_ch;

    assign single = act[B_SINGLE];
    assign fix_ch = act[CH_HI:CH_LO];

    always_comb begin
        sel = '0;
        unique case (st)
            ST_FIXED: begin
                sel.pos     = fix_ch;
                sel.neg     = single ? '0 : (fix_ch ^ CH_W'(1));
                sel.neg_com = single;
            end
            ST_SCAN: begin
                sel.pos     = cur;
                sel.neg     = single ? '0 : (cur | CH_W'(1));
                sel.neg_com = single;
            end
            ST_TEMP: begin
                sel.temp = 1'b1;
            end
            default: sel = '0;
        endcase
    end
endmodule

// File: rtl/adcseq_scan_fsm.sv
module adcseq_scan_fsm
    import adcseq_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv_start,
    input  logic [W-1:0] stg_word,
    input  logic         stg_pend,
    output sel_t         sel_q,
    output logic         sel_valid
);
    scan_st_e        st_q, st_d;
    logic [CH_W-1:0] cur_q, cur_d;
    logic            tmp_q, tmp_d;
    logic [W-1:0]    act_q, act_d;
    logic            single;
    logic [CH_W-1:0] last, last_sel, step;
    logic            restruct;
    sel_t            sel_c;

    assign single   = act_q[B_SINGLE];
    assign last     = act_q[CH_HI:CH_LO];
    assign last_sel = single ? last : {last[CH_W-1:1], 1'b0};
    assign step     = single ? CH_W'(1) : CH_W'(2);
    assign restruct = (stg_word[B_SINGLE] != act_q[B_SINGLE]) ||
                      (stg_word[CH_HI:CH_LO] != act_q[CH_HI:CH_LO]);

    // next state: advance, then apply a staged word
    always_comb begin
        st_d  = st_q;
        cur_d = cur_q;
        tmp_d = tmp_q;
        act_d = act_q;
        if (conv_start) begin
            unique case (st_q)
                ST_FIXED: begin
                    st_d = ST_FIXED;
                end
                ST_SCAN: begin
                    if (cur_q == last_sel) begin
                        cur_d = '0;
                        st_d  = tmp_q ? ST_TEMP : ST_SCAN;
                    end else begin
                        cur_d = cur_q + step;
                    end
                end
                ST_TEMP: begin
                    st_d  = ST_SCAN;
                    cur_d = '0;
                end
                default: st_d = ST_FIXED;
            endcase
            if (stg_pend) begin
                act_d = stg_word;
                unique case (stg_word[SQ_HI:SQ_LO])
                    2'b00: begin
                        st_d  = ST_FIXED;
                        cur_d = '0;
                    end
                    2'b01: begin
                        if (st_q != ST_FIXED && restruct) begin
                            st_d  = ST_SCAN;
                            cur_d = '0;
                        end
                    end
                    2'b10: begin
                        st_d  = ST_SCAN;
                        cur_d = '0;
                        tmp_d = 1'b1;
                    end
                    2'b11: begin
                        st_d  = ST_SCAN;
                        cur_d = '0;
                        tmp_d = 1'b0;
                    end
                    default: st_d = st_q;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_FIXED;
            cur_q <= '0;
            tmp_q <= 1'b0;
            act_q <= '1;
        end else begin
            st_q  <= st_d;
            cur_q <= cur_d;
            tmp_q <= tmp_d;
            act_q <= act_d;
        end
    end

    adcseq_chan_map #(.W(W)) map_i (
        .st  (st_q),
        .cur (cur_q),
        .act (act_q),
        .sel (sel_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q     <= '{pos: CH_W'(7), neg: '0, neg_com: 1'b1, temp: 1'b0};
            sel_valid <= 1'b0;
        end else begin
            if (conv_start) begin
                sel_q <= sel_c;
            end
            sel_valid <= conv_start;
        end
    end

    assert_cursor_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SCAN) |-> (cur_q <= act_q[CH_HI:CH_LO]));

    assert_pair_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SCAN && !act_q[B_SINGLE]) |-> (cur_q[0] == 1'b0));

    assert_temp_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && st_q == ST_TEMP && !stg_pend) |=> (st_q == ST_SCAN && cur_q == '0));

    assert_temp_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q.temp |-> (!sel_q.neg_com && sel_q.pos == '0));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_start |=> $stable(sel_q));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adcseq_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_bit,
    input  logic            cfg_bit_en,
    input  logic            frame_end,
    input  logic            conv_start,
    output logic [CH_W-1:0] pos_ch,
    output logic [CH_W-1:0] neg_ch,
    output logic            neg_com,
    output logic            temp_sel,
    output logic            sel_valid
);
    logic [W-1:0] stg_word;
    logic         stg_pend;
    sel_t         sel_q;

    adcseq_cfg_shift #(.W(W)) shift_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_in     (cfg_bit),
        .bit_en     (cfg_bit_en),
        .frame_end  (frame_end),
        .conv_start (conv_start),
        .stg_word   (stg_word),
        .stg_pend   (stg_pend)
    );

    adcseq_scan_fsm #(.W(W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .stg_word   (stg_word),
        .stg_pend   (stg_pend),
        .sel_q      (sel_q),
        .sel_valid  (sel_valid)
    );

    assign pos_ch   = sel_q.pos;
    assign neg_ch   = sel_q.neg;
    assign neg_com  = sel_q.neg_com;
    assign temp_sel = sel_q.temp;
endmodule

// File: tb/adc_scan_seq_tb_top.sv
module adc_scan_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_bit = 1'b0;
    logic       cfg_bit_en = 1'b0;
    logic       frame_end = 1'b0;
    logic       conv_start = 1'b0;
    logic [2:0] pos_ch, neg_ch;
    logic       neg_com, temp_sel, sel_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    adc_scan_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_bit(cfg_bit), .cfg_bit_en(cfg_bit_en),
        .frame_end(frame_end), .conv_start(conv_start), .pos_ch(pos_ch),
        .neg_ch(neg_ch), .neg_com(neg_com), .temp_sel(temp_sel), .sel_valid(sel_valid)
    );

    // reference model state: 0 fixed, 1 scan, 2 temp
    logic [13:0] m_act = 14'h3fff;
    logic [13:0] m_stg = 14'h3fff;
    bit          m_pend = 0;
    int          m_st = 0;
    int          m_cur = 0;
    bit          m_tmp = 0;
    int          e_pos = 7, e_neg = 0;
    bit          e_com = 1, e_temp = 0;

    task automatic m_frame(input logic [13:0] w, input int n);
        if (n >= 14 && w[13]) begin
            m_stg  = w;
            m_pend = 1;
        end
    endtask

    task automatic m_conv();
        bit single;
        int last, lastp, fix;
        single = m_act[11];
        fix    = int'(m_act[9:7]);
        last   = fix;
        lastp  = single ? last : (last & 6);
        e_temp = 0; e_pos = 0; e_neg = 0; e_com = 0;
        if (m_st == 0) begin
            e_pos = fix; e_com = single; e_neg = single ? 0 : (fix ^ 1);
        end else if (m_st == 1) begin
            e_pos = m_cur; e_com = single; e_neg = single ? 0 : m_cur + 1;
            if (m_cur == lastp) begin
                m_cur = 0;
                m_st  = m_tmp ? 2 : 1;
            end else m_cur = m_cur + (single ? 1 : 2);
        end else begin
            e_temp = 1; m_st = 1; m_cur = 0;
        end
        if (m_pend) begin
            case (m_stg[2:1])
                2'b00: begin m_st = 0; m_cur = 0; end
                2'b01: if (m_st_was_scan(m_st, e_temp) &&
                           (m_stg[11] != m_act[11] || m_stg[9:7] != m_act[9:7])) begin
                           m_st = 1; m_cur = 0;
                       end
                2'b10: begin m_st = 1; m_cur = 0; m_tmp = 1; end
                default: begin m_st = 1; m_cur = 0; m_tmp = 0; end
            endcase
            m_act  = m_stg;
            m_pend = 0;
        end
    endtask

    // scanning before this conversion iff not in fixed mode
    function automatic bit m_st_was_scan(input int st_after, input bit was_temp);
        return (st_after != 0) || was_temp;
    endfunction

    task automatic check(input string tag, input bit exp_vld);
        n_chk++;
        if (pos_ch !== 3'(e_pos) || neg_ch !== 3'(e_neg) || neg_com !== e_com ||
            temp_sel !== e_temp || sel_valid !== exp_vld) begin
            n_bad++;
            $display("FAIL %s: got pos=%0d neg=%0d com=%0b tmp=%0b vld=%0b exp pos=%0d neg=%0d com=%0b tmp=%0b vld=%0b",
                     tag, pos_ch, neg_ch, neg_com, temp_sel, sel_valid,
                     e_pos, e_neg, e_com, e_temp, exp_vld);
        end
    endtask

    task automatic conv(input string tag);
        @(negedge clk) conv_start = 1'b1;
        @(negedge clk) conv_start = 1'b0;
        m_conv();
        check(tag, 1'b1);
    endtask

    task automatic send(input logic [13:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cfg_bit_en = 1'b1;
            cfg_bit    = w[13-i];
        end
        @(negedge clk) begin cfg_bit_en = 1'b0; frame_end = 1'b1; end
        @(negedge clk) frame_end = 1'b0;
        m_frame(w, n);
    endtask

    function automatic logic [13:0] mk(input bit lead, input bit single,
                                       input int ch, input int code);
        return {lead, 1'b0, single, 1'b0, 3'(ch), 4'b0, 2'(code), 1'b0};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", 1'b0);

        send(mk(1, 1, 3, 0), 14);
        conv("R4 old word still used");
        conv("R4 R5 fixed single ch3");
        repeat (4) @(negedge clk);
        check("R11 hold without conv_start", 1'b0);

        send(mk(0, 1, 5, 0), 14);
        conv("R2 lead bit low");
        conv("R2 lead bit low kept");
        send(mk(1, 1, 6, 0), 10);
        conv("R3 short frame");
        conv("R3 short frame kept");

        send(mk(1, 0, 5, 0), 14);
        conv("R5 fixed pair pending");
        conv("R5 fixed pair odd ch");

        send(mk(1, 0, 5, 3), 14);
        conv("R7 pending");
        for (int i = 0; i < 5; i++) conv("R7 paired scan");

        send(mk(1, 1, 2, 2), 14);
        conv("R8 pending");
        for (int i = 0; i < 9; i++) conv("R8 R6 scan with temp");

        send(mk(1, 1, 2, 1) | 14'h0040, 14);
        conv("R9 update pending");
        for (int i = 0; i < 4; i++) conv("R9 scan continues");

        send(mk(1, 1, 4, 1), 14);
        conv("R10 pending");
        for (int i = 0; i < 4; i++) conv("R10 restart at input 0");

        send(mk(1, 1, 6, 3), 14);
        conv("R8 code 11 pending");
        for (int i = 0; i < 9; i++) conv("R6 R8 scan without temp");

        for (int it = 0; it < 400; it++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 35) begin
                logic [13:0] w;
                w = 14'($urandom);
                w[13] = ($urandom_range(0, 9) != 0);
                send(w, ($urandom_range(0, 9) == 0) ? int'($urandom_range(1, 13)) : 14);
            end
            conv("R5 R6 R7 R8 R9 R10 random");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule